// File: doc/BRIEF.md
# Parallel EPROM Byte Read Controller

This block sits on the host side of one or more asynchronous byte-wide EPROMs that share a 20-bit address bus, an 8-bit data bus and a common output-enable line. A client hands it a read request (bank number in the upper request bits, byte address in the lower bits) over a valid/ready handshake. The controller then sequences the device pins: it presents the address, pulls the chip enable of the addressed device low, pulls the shared output enable low, holds both long enough to cover the device's three access paths, samples the data bus and returns the byte with a one-cycle valid strobe.

All device delays are given as picosecond parameters together with the clock period. They are turned into cycle counts by rounding up, never below one cycle. The output enable is delayed after the chip enable by the difference of the two access times, so that the address, chip-enable and output-enable paths all mature on the same sampling edge. After the strobes are released, the controller holds off any new request for the data-float interval, so no other driver can meet the device on the data bus.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While the synchronous active-low reset is low, and on the cycle after it, every chip enable and the output enable are high and the response strobe is low; the ready output is low for as long as reset is low.
- R2: Ready is high only when the controller is idle. A request is taken on a clock edge where valid and ready are both high, and the address presented then is latched for the whole access.
- R3: Only the device whose number equals the top BANK_W request bits gets its active-low chip enable (bit index = bank number) driven low. All others stay high.
- R4: The output enable is never low unless some chip enable is low.
- R5: With GD = max(1, ACC - OE), the address is driven on the cycle after acceptance, the chip enable falls one cycle later, and the output enable falls GD cycles after the chip enable. All cycle counts are ceil(delay / clock period), at least 1.
- R6: The data bus is sampled on the edge that ends the cycle in which the chip enable has been low for GD + OE cycles. At that point at least ACC cycles have passed since the address changed and since the chip enable fell, and at least OE cycles since the output enable fell.
- R7: The address output does not change while any chip enable is low. The byte is captured before the address moves.
- R8: The response strobe is high for exactly one cycle, on the cycle after sampling, and the response data then equals the sampled byte. In that same cycle both enables are already high.
- R9: After the enables rise, ready stays low for DF cycles (the float time rounded up) before the next request can be taken.
- R10: A request presented while the controller is busy is not taken and does not disturb the access in progress. A request held high across the end of an access is taken on the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | BANK_W+ADDR_W | Bank number (upper bits) and byte address |
| rsp_valid | output | 1 | One-cycle strobe, read data valid |
| rsp_data | output | DATA_W | Byte read from the device |
| mem_addr | output | ADDR_W | Address bus to all devices |
| mem_ce_n | output | 2**BANK_W | Per-device chip enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq | input | DATA_W | Data bus from the devices |

## Verification
The bench's device model only returns the true byte when the address, chip-enable and output-enable ages all reach their minimums, and otherwise returns corrupted data. A controller that samples one cycle early, or that raises the output enable too soon, therefore returns a wrong byte. Requests are held valid through whole accesses and across access boundaries with a changing address. A controller that takes a request while busy would latch the wrong address or start a second access, and one that skips the float hold-off would raise ready too early. A reset in the middle of a read checks that the strobes drop at once and that the next read starts cleanly. The float time is set to a value that is not a whole number of clock periods, which exposes truncation instead of rounding up.

// File: rtl/eprom_rd_pkg.sv
// Package: shared state type and the delay-to-cycle conversion of the
// EPROM read controller. Assumes all delays are non-negative integers.
package eprom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ASSERT,
        ST_WAIT,
        ST_CAPTURE,
        ST_FLOAT
    } rd_state_e;

    // Rounds a delay up to whole clock periods, never below one cycle.
    function automatic int unsigned dly2cyc(input int unsigned dly_ps,
                                            input int unsigned per_ps);
        int unsigned c;
        c = (dly_ps + per_ps - 1) / per_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
// Down-counter that times one FSM state. A load of N-1 on state entry
// makes the state last N cycles; done is high in the last one.
// Assumes load is only pulsed on state transitions.
module eprom_rd_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: reload on state entry, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/eprom_bank_dec.sv
// Turns the bank number into per-device active-low chip enables.
// At most one output is low, and only while en is high.
module eprom_bank_dec #(
    parameter int BANK_W = 2,
    localparam int NUM_DEV = 1 << BANK_W
) (
    input  logic [BANK_W-1:0]  bank,
    input  logic               en,
    output logic [NUM_DEV-1:0] sel_n
);
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        assign sel_n[d] = !(en && (bank == BANK_W'(d)));
    end
endmodule

// File: rtl/eprom_rd_ctrl.sv
// Host-side read controller for byte-wide asynchronous EPROMs.
// Sequences address, chip enable and shared output enable so that all
// three access paths mature on one sampling edge, then holds off new
// requests for the data-float time. Assumes the clock period and all
// delays are given in picoseconds and the devices share the data bus.
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int BANK_W    = 2,
    parameter int CLK_PS    = 5000,
    parameter int T_ACC_PS  = 150000,
    parameter int T_OE_PS   = 50000,
    parameter int T_DF_PS   = 40000,
    localparam int NUM_DEV  = 1 << BANK_W,
    localparam int REQ_W    = BANK_W + ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [REQ_W-1:0]   req_addr,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [NUM_DEV-1:0] mem_ce_n,
    output logic               mem_oe_n,
    input  logic [DATA_W-1:0]  mem_dq
);
    localparam int ACC_C  = int'(dly2cyc(T_ACC_PS, CLK_PS));
    localparam int OE_C   = int'(dly2cyc(T_OE_PS, CLK_PS));
    localparam int DF_C   = int'(dly2cyc(T_DF_PS, CLK_PS));
    localparam int GD_C   = (ACC_C - OE_C < 1) ? 1 : ACC_C - OE_C;
    localparam int MAX_C  = (GD_C > OE_C) ? ((GD_C > DF_C) ? GD_C : DF_C)
                                          : ((OE_C > DF_C) ? OE_C : DF_C);
    localparam int CNT_W  = $clog2(MAX_C + 1);

    rd_state_e        st_q, st_d;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic [REQ_W-1:0] addr_q;
    logic             ce_on;

    // Next state and timer reload for each state transition.
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st_q)
            ST_IDLE:    if (req_valid) st_d = ST_SETUP;
            ST_SETUP: begin
                st_d     = ST_ASSERT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(GD_C - 1);
            end
            ST_ASSERT: if (tmr_done) begin
                st_d     = ST_WAIT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(OE_C - 1);
            end
            ST_WAIT:    if (tmr_done) st_d = ST_CAPTURE;
            ST_CAPTURE: begin
                st_d     = ST_FLOAT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(DF_C - 1);
            end
            ST_FLOAT:   if (tmr_done) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Request address latch, loaded only when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (st_q == ST_IDLE && req_valid)
            addr_q <= req_addr;
    end

    // Data capture and one-cycle response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= (st_q == ST_CAPTURE);
            if (st_q == ST_CAPTURE) rsp_data <= mem_dq;
        end
    end

    eprom_rd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign ce_on = (st_q == ST_ASSERT) || (st_q == ST_WAIT) || (st_q == ST_CAPTURE);

    eprom_bank_dec #(.BANK_W(BANK_W)) u_dec (
        .bank  (addr_q[REQ_W-1:ADDR_W]),
        .en    (ce_on),
        .sel_n (mem_ce_n)
    );

    assign mem_addr  = addr_q[ADDR_W-1:0];
    assign mem_oe_n  = !((st_q == ST_WAIT) || (st_q == ST_CAPTURE));
    assign req_ready = rst_n && (st_q == ST_IDLE);
endmodule

// File: rtl/eprom_rd_chk.sv
// Property checker for the EPROM read controller, bound to every
// instance. Observes ports only; assumes the synchronous active-low reset.
module eprom_rd_chk #(
    parameter int ADDR_W  = 20,
    parameter int NUM_DEV = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [NUM_DEV-1:0] mem_ce_n,
    input logic               mem_oe_n
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (&mem_ce_n) && mem_oe_n && !rsp_valid);

    a_r3_single_device: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ce_n));

    a_r4_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !(&mem_ce_n));

    a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(&mem_ce_n) |=> (&mem_ce_n) || $stable(mem_addr));

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r8_strobe_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (&mem_ce_n) && mem_oe_n);

    a_r9_float_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !req_ready);

    a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&mem_ce_n) && mem_oe_n);
endmodule

bind eprom_rd_ctrl eprom_rd_chk #(.ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n)
);

// File: tb/eprom_rd_ctrl_bench.sv
`timescale 1ns/100ps
module eprom_rd_ctrl_bench;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 8;
    localparam int BANK_W = 2;
    localparam int NDEV   = 4;
    localparam int REQ_W  = ADDR_W + BANK_W;
    localparam int CLK_PS = 5000;
    localparam int ACC_PS = 150000;
    localparam int OE_PS  = 50000;
    localparam int DF_PS  = 38000;
    // Expected cycle counts from R5/R9: ceil, minimum 1.
    localparam int ACC = (ACC_PS + CLK_PS - 1) / CLK_PS;   // 30
    localparam int OE  = (OE_PS + CLK_PS - 1) / CLK_PS;    // 10
    localparam int DF  = (DF_PS + CLK_PS - 1) / CLK_PS;    // 8
    localparam int GD  = (ACC - OE < 1) ? 1 : ACC - OE;    // 20
    localparam int CAP = GD + OE + 1;                      // sampling cycle index

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [REQ_W-1:0] req_addr = '0;
    logic req_ready, rsp_valid, mem_oe_n;
    logic [DATA_W-1:0] rsp_data, mem_dq;
    logic [ADDR_W-1:0] mem_addr;
    logic [NDEV-1:0] mem_ce_n;

    int checks = 0;
    int fails  = 0;
    int t = -1;            // cycle index within an access, -1 when idle
    int taken = 0;         // requests taken by the reference model
    logic [REQ_W-1:0] exp_addr = '0;
    int e_age = 0, g_age = 0, a_age = 0;
    logic [ADDR_W-1:0] a_prev = '0;

    always #2.5 clk = ~clk;

    eprom_rd_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .CLK_PS(CLK_PS),
        .T_ACC_PS(ACC_PS), .T_OE_PS(OE_PS), .T_DF_PS(DF_PS)
    ) u_eprom_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_dq(mem_dq)
    );

    function automatic logic [7:0] rom_byte(input logic [REQ_W-1:0] a);
        logic [31:0] h;
        h = 32'(a) * 32'd2654435761;
        return h[23:16] ^ h[7:0];
    endfunction

    // Device model: true byte only once all three access paths matured.
    always_comb begin
        int sel;
        int low;
        sel = 0;
        low = 0;
        for (int d = 0; d < NDEV; d++)
            if (!mem_ce_n[d]) begin sel = d; low++; end
        if (low == 1 && !mem_oe_n && e_age >= ACC && g_age >= OE && a_age >= ACC)
            mem_dq = rom_byte({BANK_W'(sel), mem_addr});
        else
            mem_dq = rom_byte({BANK_W'(sel), mem_addr}) ^ 8'h5A;
    end

    // Age counters of the device model.
    always @(posedge clk) begin
        e_age  <= (&mem_ce_n) ? 0 : e_age + 1;
        g_age  <= mem_oe_n ? 0 : g_age + 1;
        a_age  <= (mem_addr != a_prev) ? 0 : a_age + 1;
        a_prev <= mem_addr;
    end

    // Reference model: access timeline per R2, R5, R9, R10.
    always @(posedge clk) begin
        if (!rst_n) t = -1;
        else if (t < 0) begin
            if (req_valid) begin t = 0; exp_addr = req_addr; taken++; end
        end else if (t == CAP + DF) t = -1;
        else t++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the reference model away from the edge.
    always @(negedge clk) begin
        logic exp_rdy, exp_ce, exp_oe, exp_rv;
        logic [NDEV-1:0] ce_exp;
        exp_rdy = rst_n && (t < 0);
        exp_ce  = (t >= 1 && t <= CAP);
        exp_oe  = (t >= GD + 1 && t <= CAP);
        exp_rv  = (t == CAP + 1);
        ce_exp  = exp_ce ? ~(NDEV'(1) << exp_addr[REQ_W-1:ADDR_W]) : '1;
        chk(req_ready == exp_rdy, "R2/R9", "ready", 32'(req_ready), 32'(exp_rdy));
        chk(mem_ce_n == ce_exp, "R3/R5", "ce_n", 32'(mem_ce_n), 32'(ce_exp));
        chk(mem_oe_n == !exp_oe, "R4/R5", "oe_n", 32'(mem_oe_n), 32'(!exp_oe));
        chk(rsp_valid == exp_rv, "R8", "rsp_valid", 32'(rsp_valid), 32'(exp_rv));
        if (t >= 0 && t <= CAP)
            chk(mem_addr == exp_addr[ADDR_W-1:0], "R7", "mem_addr",
                32'(mem_addr), 32'(exp_addr[ADDR_W-1:0]));
        if (exp_rv)
            chk(rsp_data == rom_byte(exp_addr), "R6", "rsp_data",
                32'(rsp_data), 32'(rom_byte(exp_addr)));
        if (!rst_n)
            chk((&mem_ce_n) || t >= 0, "R1", "reset quiet", 32'(mem_ce_n), 32'('1));
    end

    // One read: hold the request until the model takes it, then drop it.
    task automatic rd(input logic [REQ_W-1:0] a);
        int n0;
        n0 = taken;
        req_valid = 1'b1;
        req_addr  = a;
        while (taken == n0) begin @(posedge clk); #1; end
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (t >= 0) begin @(posedge clk); #1; end
        repeat (2) begin @(posedge clk); #1; end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) begin @(posedge clk); #1; end
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R3/R6: one read per bank, extreme and mixed addresses
        rd({2'd0, 20'h00000}); wait_idle();
        rd({2'd3, 20'hFFFFF}); wait_idle();
        rd({2'd1, 20'h5A5A5}); wait_idle();
        rd({2'd2, 20'h12345}); wait_idle();
        // R10: request held valid with a changing address during busy
        req_valid = 1'b1;
        for (int i = 0; i < 3 * (CAP + DF); i++) begin
            req_addr = REQ_W'(i * 32'h2F3B1 + 7);
            @(posedge clk); #1;
        end
        req_valid = 1'b0;
        wait_idle();
        // R10: back-to-back requests, taken right after the float
        rd({2'd1, 20'hABCDE});
        req_valid = 1'b1;
        req_addr  = {2'd2, 20'h00F0F};
        while (taken < 8) begin @(posedge clk); #1; end
        req_valid = 1'b0;
        wait_idle();
        // R1: reset in the middle of an access, then a clean read
        rd({2'd3, 20'h33333});
        repeat (GD + 3) begin @(posedge clk); #1; end
        rst_n = 1'b0;
        repeat (2) begin @(posedge clk); #1; end
        rst_n = 1'b1;
        @(posedge clk); #1;
        rd({2'd0, 20'h80001}); wait_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule